// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit, Two-Step Trellis

This unit produces the branch metrics that feed the add-compare-select array of a rate-1/2 convolutional decoder. The decoder works on 3-bit soft samples with eight levels. A received pair carries one soft sample for each of the two code bits. For every hypothesis of the two code bits, the unit measures how far the received pair lies from the ideal pair. It uses the sum of the absolute differences, which is the Manhattan distance.

To let the decoder advance two trellis steps per clock, the unit takes two consecutive received pairs at once: an earlier pair and a later pair. Each pair goes through its own single-step metric generator, which produces four metrics. A combiner then adds every earlier-step metric to every later-step metric, which gives the sixteen metrics of a two-bit transition.

All outputs are registered. A two-state controller tracks whether the registered metrics are fresh:
- **ST_IDLE**: no fresh metrics.
- **ST_EMIT**: fresh metrics from the previous cycle.

The controller has four transitions:
- ST_IDLE to ST_EMIT when `in_valid` is high.
- ST_EMIT stays in ST_EMIT when `in_valid` is high.
- ST_EMIT to ST_IDLE when `in_valid` is low.
- ST_IDLE stays in ST_IDLE when `in_valid` is low.

Top module: `bmu_r4`

## Requirements
- R1: A code bit of 0 is expected as soft value 0 and a code bit of 1 as soft value 7. The distance of a sample g is therefore g for bit 0 and 7-g for bit 1.
- R2: Lane k of `r2_metric` (bits [4k+3:4k]) holds the metric of the earlier pair for the hypothesis k={c1,c2}. Bit 1 of k is the hypothesis for `early_g1` and bit 0 is the hypothesis for `early_g2`. The value is dist(early_g1,c1)+dist(early_g2,c2).
- R3: Every lane of `r2_metric` is at most 14. Lanes k and 3-k always sum to 14.
- R4: Lane j={a1,a0,b1,b0} of `r4_metric` (bits [5j+4:5j]) holds the earlier-pair metric for hypothesis {a1,a0} plus the later-pair metric for hypothesis {b1,b0}. The later pair uses the same per-symbol rule as R2.
- R5: Every lane of `r4_metric` is at most 28. Lanes j and 15-j always sum to 28.
- R6: `out_valid` is high in the cycle after `in_valid` is sampled high, and low in the cycle after `in_valid` is sampled low.
- R7: While `in_valid` is low, the sample inputs are ignored and both metric outputs keep their previous values.
- R8: An active-low `rst_n` clears `out_valid` and every metric lane to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The sample inputs hold a pair of trellis steps |
| early_g1 | input | 3 | Soft sample, first code bit, earlier step |
| early_g2 | input | 3 | Soft sample, second code bit, earlier step |
| late_g1 | input | 3 | Soft sample, first code bit, later step |
| late_g2 | input | 3 | Soft sample, second code bit, later step |
| out_valid | output | 1 | Registered metrics are fresh |
| r2_metric | output | 16 | Four single-step metrics of the earlier pair, 4 bits each |
| r4_metric | output | 80 | Sixteen two-step metrics, 5 bits each |

## Verification
The properties assume that `in_valid` is a known level at every rising edge once reset is released. They also assume the sample inputs are settled by that edge. They place no restriction on the sample values themselves, since the mirror and additive-split relations hold for any 3-bit input. The stimulus drives every input only on falling clock edges and keeps `in_valid` at a defined level throughout. It covers all 64 earlier-pair combinations, each paired with a distinct later pair, plus runs in which `in_valid` is dropped while the samples keep changing.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    // Hypotheses per trellis step (two code bits).
    localparam int N_R2 = 4;
    // Hypotheses over two trellis steps.
    localparam int N_R4 = N_R2 * N_R2;
    // Received pairs accepted per cycle.
    localparam int N_STEPS = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } bmu_state_e;

endpackage

// File: rtl/sym_dist.sv
module sym_dist #(
    parameter int SOFT_W = 3
) (
    input  logic [SOFT_W-1:0] g,
    output logic [SOFT_W-1:0] d_zero,
    output logic [SOFT_W-1:0] d_one
);

    // Ideal soft values are all-zeros (bit 0) and all-ones (bit 1), R1.
    // The distance to all-ones is the bitwise complement.
    assign d_zero = g;
    assign d_one  = ~g;

endmodule

// File: rtl/r2_bmu.sv
module r2_bmu
    import bmu_pkg::*;
#(
    parameter int SOFT_W = 3,
    parameter int MW     = SOFT_W + 1
) (
    input  logic [SOFT_W-1:0]    g1,
    input  logic [SOFT_W-1:0]    g2,
    output logic [N_R2*MW-1:0]   metrics
);

    logic [SOFT_W-1:0] d1_zero, d1_one, d2_zero, d2_one;

    sym_dist #(.SOFT_W(SOFT_W)) u_d1 (
        .g      (g1),
        .d_zero (d1_zero),
        .d_one  (d1_one)
    );

    sym_dist #(.SOFT_W(SOFT_W)) u_d2 (
        .g      (g2),
        .d_zero (d2_zero),
        .d_one  (d2_one)
    );

    // Lane k = {c1, c2}; c1 selects the hypothesis for g1, c2 for g2 (R2).
    for (genvar k = 0; k < N_R2; k++) begin : g_lane
        localparam bit C1 = (k / 2) == 1;
        localparam bit C2 = (k % 2) == 1;
        logic [SOFT_W-1:0] p1, p2;
        assign p1 = C1 ? d1_one : d1_zero;
        assign p2 = C2 ? d2_one : d2_zero;
        assign metrics[k*MW +: MW] = MW'(p1) + MW'(p2);
    end

endmodule

// File: rtl/r4_combine.sv
module r4_combine
    import bmu_pkg::*;
#(
    parameter int MW = 4,
    parameter int QW = MW + 1
) (
    input  logic [N_R2*MW-1:0] early_m,
    input  logic [N_R2*MW-1:0] late_m,
    output logic [N_R4*QW-1:0] sums
);

    // Lane j = {a, b}: a names the earlier hypothesis, b the later one (R4).
    for (genvar j = 0; j < N_R4; j++) begin : g_sum
        localparam int A = j / N_R2;
        localparam int B = j % N_R2;
        assign sums[j*QW +: QW] = QW'(early_m[A*MW +: MW]) + QW'(late_m[B*MW +: MW]);
    end

endmodule

// File: rtl/bmu_r4.sv
module bmu_r4
    import bmu_pkg::*;
#(
    parameter  int SOFT_W = 3,
    localparam int R2_W   = SOFT_W + 1,
    localparam int R4_W   = R2_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [SOFT_W-1:0]      early_g1,
    input  logic [SOFT_W-1:0]      early_g2,
    input  logic [SOFT_W-1:0]      late_g1,
    input  logic [SOFT_W-1:0]      late_g2,
    output logic                   out_valid,
    output logic [N_R2*R2_W-1:0]   r2_metric,
    output logic [N_R4*R4_W-1:0]   r4_metric
);

    logic [SOFT_W-1:0]    g1_arr [N_STEPS];
    logic [SOFT_W-1:0]    g2_arr [N_STEPS];
    logic [N_R2*R2_W-1:0] step_m [N_STEPS];
    logic [N_R4*R4_W-1:0] r4_next;

    assign g1_arr[0] = early_g1;
    assign g2_arr[0] = early_g2;
    assign g1_arr[1] = late_g1;
    assign g2_arr[1] = late_g2;

    // One single-step metric generator per received pair.
    for (genvar s = 0; s < N_STEPS; s++) begin : g_step
        r2_bmu #(.SOFT_W(SOFT_W), .MW(R2_W)) u_r2 (
            .g1      (g1_arr[s]),
            .g2      (g2_arr[s]),
            .metrics (step_m[s])
        );
    end

    r4_combine #(.MW(R2_W), .QW(R4_W)) u_comb (
        .early_m (step_m[0]),
        .late_m  (step_m[1]),
        .sums    (r4_next)
    );

    // Freshness controller.
    bmu_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EMIT;
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers: load on a valid pair, hold otherwise (R7, R8).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r2_metric <= '0;
            r4_metric <= '0;
        end else if (in_valid) begin
            r2_metric <= step_m[0];
            r4_metric <= r4_next;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/bmu_r4_chk.sv
module bmu_r4_chk
    import bmu_pkg::*;
#(
    parameter  int SOFT_W = 3,
    localparam int R2_W   = SOFT_W + 1,
    localparam int R4_W   = R2_W + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [N_R2*R2_W-1:0] r2_metric,
    input logic [N_R4*R4_W-1:0] r4_metric
);

    localparam int R2_SUM = 2 * ((1 << SOFT_W) - 1);
    localparam int R4_SUM = 2 * R2_SUM;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6

    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(r2_metric) && $stable(r4_metric))); // R7

    for (genvar k = 0; k < N_R2; k++) begin : g_r2
        AST_R2_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (int'(r2_metric[k*R2_W +: R2_W])
                         + int'(r2_metric[(N_R2-1-k)*R2_W +: R2_W])) == R2_SUM); // R3
    end

    for (genvar j = 0; j < N_R4; j++) begin : g_r4
        localparam int A = j / N_R2;
        localparam int B = j % N_R2;
        AST_R4_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (int'(r4_metric[j*R4_W +: R4_W])
                         + int'(r4_metric[(N_R4-1-j)*R4_W +: R4_W])) == R4_SUM); // R5
        if (A != 0) begin : g_split
            AST_R4_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (int'(r4_metric[j*R4_W +: R4_W]) - int'(r2_metric[A*R2_W +: R2_W]))
                           == (int'(r4_metric[B*R4_W +: R4_W]) - int'(r2_metric[0 +: R2_W]))); // R4
        end
    end

endmodule

bind bmu_r4 bmu_r4_chk #(.SOFT_W(SOFT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .r2_metric (r2_metric),
    .r4_metric (r4_metric)
);

// File: tb/sim_bmu_r4.sv
`timescale 1ns/1ps
module sim_bmu_r4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  early_g1 = '0, early_g2 = '0, late_g1 = '0, late_g2 = '0;
    logic        out_valid;
    logic [15:0] r2_metric;
    logic [79:0] r4_metric;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bmu_r4 u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .early_g1  (early_g1),
        .early_g2  (early_g2),
        .late_g1   (late_g1),
        .late_g2   (late_g2),
        .out_valid (out_valid),
        .r2_metric (r2_metric),
        .r4_metric (r4_metric)
    );

    // Stimulus table {early_g1, early_g2, late_g1, late_g2}, octal digits.
    localparam logic [11:0] VEC [16] = '{
        12'o0000, 12'o7777, 12'o0707, 12'o7070,
        12'o3456, 12'o6543, 12'o1234, 12'o4321,
        12'o0077, 12'o7700, 12'o3344, 12'o4433,
        12'o1526, 12'o2615, 12'o0417, 12'o7163
    };

    // Behavioural model (R1): ideal values 0 and 7, absolute difference.
    function automatic int sdist(input int g, input int bitv);
        int ideal;
        ideal = bitv ? 7 : 0;
        return (g > ideal) ? g - ideal : ideal - g;
    endfunction

    function automatic int m2(input int g1, input int g2, input int k);
        return sdist(g1, (k >> 1) & 1) + sdist(g2, k & 1);
    endfunction

    task automatic check(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the model for the given pairs.
    task automatic check_all(input int e1, input int e2, input int l1, input int l2, input int vld);
        check(int'(out_valid), vld, "R6", "out_valid");
        for (int k = 0; k < 4; k++)
            check(int'(r2_metric[k*4 +: 4]), m2(e1, e2, k), "R2", $sformatf("r2 lane %0d", k));
        for (int j = 0; j < 16; j++)
            check(int'(r4_metric[j*5 +: 5]), m2(e1, e2, j / 4) + m2(l1, l2, j % 4),
                  "R4", $sformatf("r4 lane %0d", j));
    endtask

    // Called at a falling edge: drive, then wait one cycle and compare.
    task automatic drive_and_check(input logic [11:0] v);
        early_g1 = v[11:9]; early_g2 = v[8:6]; late_g1 = v[5:3]; late_g2 = v[2:0];
        in_valid = 1'b1;
        @(negedge clk);
        check_all(v[11:9], v[8:6], v[5:3], v[2:0], 1);
    endtask

    task automatic check_zero(input string tag);
        check(int'(out_valid), 0, "R8", {tag, " out_valid"});
        check(int'(r2_metric == '0), 1, "R8", {tag, " r2 cleared"});
        check(int'(r4_metric == '0), 1, "R8", {tag, " r4 cleared"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_zero("reset");                      // R8
        rst_n = 1'b1;

        // Table walk: R2, R4, R6.
        foreach (VEC[i]) drive_and_check(VEC[i]);

        // All 64 earlier pairs, each with a distinct later pair (R1, R2, R4).
        for (int i = 0; i < 64; i++) begin
            logic [5:0] e, l;
            e = 6'(i);
            l = 6'(63 - i);
            drive_and_check({e, l});
        end

        // R7: a drop of in_valid with moving samples keeps the outputs.
        drive_and_check(12'o3456);
        in_valid = 1'b0;
        early_g1 = 3'd7; early_g2 = 3'd0; late_g1 = 3'd1; late_g2 = 3'd6;
        @(negedge clk);
        check_all(3, 4, 5, 6, 0);                 // R7, R6 low
        early_g1 = 3'd2; late_g2 = 3'd2;
        @(negedge clk);
        check_all(3, 4, 5, 6, 0);                 // R7 second idle cycle

        // R3 and R5 extremes with all-zero samples.
        drive_and_check(12'o0000);
        check(int'(r2_metric[12 +: 4]), 14, "R3", "r2 max lane");
        check(int'(r2_metric[0 +: 4]), 0, "R3", "r2 min lane");
        check(int'(r4_metric[75 +: 5]), 28, "R5", "r4 max lane");
        check(int'(r4_metric[0 +: 5]), 0, "R5", "r4 min lane");

        // R8: asynchronous reset in mid-run.
        drive_and_check(12'o1526);
        rst_n = 1'b0;
        #1;
        check_zero("mid-run reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule